// File: doc/BRIEF.md
# Partition-Aware Motion Record Packer

This block sits between a motion-vector producing engine and an output queue that streams one record per macroblock to memory. The engine fills a small staging store of 16-bit cells with per-subpartition motion vectors, per-partition reference ids, zero flags, macroblock flags and a 10-bit partition code. It then pulses a start strobe. Over a fixed schedule the block walks the sixteen 4x4 subpartitions. For each one it uses masks derived from the partition code to pick which staging entry supplies the data, so a coarse partition's values are copied into every 8x8 and 4x4 block it covers. It then presents a packed sixteen-word record to the queue.

A busy status bit tells the engine when it may modify the staging store again. A full status bit tells it whether another record may be started. The block never starts a record when the queue reports no space. When the record being built will take the queue's last slot, the full status rises together with busy.

Top module: `motion_record_packer`

## Requirements
- R1: After synchronous reset, `busy`, `rec_valid` and `full_stat` are 0 while `q_full` is 0.
- R2: A `start` accepted in cycle 1 makes `busy` 1 from cycle 2 through cycle 17 (16 cycles), and 0 again in cycle 18.
- R3: `rec_valid` is 1 for exactly one cycle, cycle 18, and `rec_data` holds the full record in that cycle.
- R4: `start` while `q_full` is 1 and `busy` is 0 is ignored: `busy` and `rec_valid` stay 0.
- R5: `start` while `busy` is 1 is ignored: the running record still ends after 16 busy cycles, and no second record follows.
- R6: `full_stat` is the OR of `q_full` and an internal flag. That flag is set on an accepted start while `q_last` is 1, so it shows in cycle 2 together with `busy`. It stays set through the `rec_valid` cycle.
- R7: Staging address layout is {sub[3:0], kind[2:0]}. Kind 0 is X (14 bits) and kind 1 is Y (12 bits) of subpartition sub. Kind 2 is the reference id (5 bits) of partition sub[3:2]. Kind 3 is the zero flag (bit 0) of subpartition sub. Kind 4 holds the macroblock flags (2 bits), and kind 5 holds the partition code (10 bits).
- R8: With lut(v) mapping 0,1,2,3 to 0,2,1,3, the partition mask is pm = lut(code[1:0]). For subpartition i in partition p = i>>2, the subpartition mask is {pm, lut(code[2p+3:2p+2])}. Record word i bits 13:0 carry X and bits 25:14 carry Y of staging entry i AND that mask.
- R9: Words 0, 4, 8 and 12 carry, in bits 30:26, the reference id of partition p AND pm, where p is the word index divided by 4.
- R10: Word 4g+1 carries, in bit 26+k (k = 0..3), the zero flag of staging entry (4g+k) AND the subpartition mask of group g.
- R11: Word 15 bit 26 is flags bit 0 (frame/field) and bit 27 is flags bit 1 (intra). Every other bit from 26 to 31 in any word is 0.
- R12: Address bits a kind does not use are ignored and alias to the same storage. Data bits above a field's width are dropped. Writes to kinds 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stg_we | input | 1 | Staging write enable |
| stg_addr | input | 7 | Staging cell address {sub, kind} |
| stg_wdata | input | 16 | Staging write data |
| start | input | 1 | Start-record strobe |
| q_full | input | 1 | Output queue has no space |
| q_last | input | 1 | Output queue has exactly one free slot |
| busy | output | 1 | Gather in progress, staging must hold still |
| full_stat | output | 1 | No further record may be started |
| rec_valid | output | 1 | Record presented to the queue this cycle |
| rec_data | output | 512 | Sixteen 32-bit words, word i at bits 32i+31:32i |

## Verification
The gather runs for every one of the 1024 partition codes, against several staging fills whose values differ per subpartition and per partition. A wrong mask bit or a swapped lookup entry therefore moves data from a visibly different source. The all-ones code makes every mask the identity, which isolates field placement from the masking. Separate runs write through aliased and reserved addresses and with oversized data, and hold `q_full` or `q_last`, or pulse `start` mid-gather, to separate the acceptance rules from the datapath.

// File: rtl/mrp_pkg.sv
package mrp_pkg;

    localparam int SUBS   = 16;
    localparam int PARTS  = 4;
    localparam int SUBW   = $clog2(SUBS);
    localparam int PARTW  = $clog2(PARTS);
    localparam int GRP    = SUBS / PARTS;
    localparam int XW     = 14;
    localparam int YW     = 12;
    localparam int RIDW   = 5;
    localparam int FLGW   = 2;
    localparam int CODEW  = 10;
    localparam int CELLW  = 16;
    localparam int KINDW  = 3;
    localparam int ADDRW  = SUBW + KINDW;
    localparam int WORDW  = 32;
    localparam int UPW    = WORDW - XW - YW;
    localparam int RECW   = SUBS * WORDW;
    localparam int LASTSTEP = SUBS - 1;

    // Motion vector as it sits in the low bits of a record word.
    typedef struct packed {
        logic [YW-1:0] y;
        logic [XW-1:0] x;
    } mv_t;

    typedef enum logic [KINDW-1:0] {
        K_X     = 3'd0,
        K_Y     = 3'd1,
        K_RID   = 3'd2,
        K_ZERO  = 3'd3,
        K_FLAGS = 3'd4,
        K_CODE  = 3'd5,
        K_RSV6  = 3'd6,
        K_RSV7  = 3'd7
    } kind_e;

    typedef struct packed {
        logic [SUBW-1:0] sub;
        kind_e           kind;
    } saddr_t;

    // Two-bit lookup: swaps the bits of a coarse split code into a mask.
    function automatic logic [1:0] split_lut(input logic [1:0] v);
        return {v[0], v[1]};
    endfunction

    function automatic logic [PARTW-1:0] part_mask(input logic [CODEW-1:0] code);
        return split_lut(code[1:0]);
    endfunction

    function automatic logic [SUBW-1:0] sub_mask(input logic [CODEW-1:0] code,
                                                 input logic [PARTW-1:0] p);
        logic [CODEW-1:0] sh;
        sh = code >> (2 * int'(p) + 2);
        return {part_mask(code), split_lut(sh[1:0])};
    endfunction

endpackage

// File: rtl/mrp_stage.sv
module mrp_stage
    import mrp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [ADDRW-1:0]    addr,
    input  logic [CELLW-1:0]    wdata,
    input  logic [SUBW-1:0]     rd_sub,
    input  logic [PARTW-1:0]    rd_part,
    output mv_t                 rd_mv,
    output logic                rd_zero,
    output logic [RIDW-1:0]     rd_rid,
    output logic [FLGW-1:0]     flags,
    output logic [CODEW-1:0]    code
);

    saddr_t           wa;
    mv_t              mv_q   [SUBS];
    logic [SUBS-1:0]  zero_q;
    logic [RIDW-1:0]  rid_q  [PARTS];
    logic [FLGW-1:0]  flg_q;
    logic [CODEW-1:0] code_q;

    assign wa = saddr_t'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SUBS; i++) mv_q[i] <= '0;
            for (int p = 0; p < PARTS; p++) rid_q[p] <= '0;
            zero_q <= '0;
            flg_q  <= '0;
            code_q <= '0;
        end else if (we) begin
            unique case (wa.kind)
                K_X:     mv_q[wa.sub].x <= wdata[XW-1:0];
                K_Y:     mv_q[wa.sub].y <= wdata[YW-1:0];
                K_RID:   rid_q[wa.sub[SUBW-1 -: PARTW]] <= wdata[RIDW-1:0];
                K_ZERO:  zero_q[wa.sub] <= wdata[0];
                K_FLAGS: flg_q <= wdata[FLGW-1:0];
                K_CODE:  code_q <= wdata[CODEW-1:0];
                default: ;
            endcase
        end
    end

    assign rd_mv   = mv_q[rd_sub];
    assign rd_zero = zero_q[rd_sub];
    assign rd_rid  = rid_q[rd_part];
    assign flags   = flg_q;
    assign code    = code_q;

endmodule

// File: rtl/mrp_seq.sv
module mrp_seq
    import mrp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            q_full,
    input  logic            q_last,
    output logic            busy,
    output logic [SUBW-1:0] step,
    output logic            rec_valid,
    output logic            full_stat
);

    logic accept;
    logic fill_q;

    assign accept = start && !q_full && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            step      <= '0;
            rec_valid <= 1'b0;
        end else begin
            rec_valid <= 1'b0;
            if (!busy) begin
                if (accept) begin
                    busy <= 1'b1;
                    step <= '0;
                end
            end else if (step == SUBW'(LASTSTEP)) begin
                busy      <= 1'b0;
                rec_valid <= 1'b1;
            end else begin
                step <= step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= 1'b0;
        end else if (accept && q_last) begin
            fill_q <= 1'b1;
        end else if (rec_valid) begin
            fill_q <= 1'b0;
        end
    end

    assign full_stat = q_full | fill_q;

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(step) == SUBW'(LASTSTEP)); // R2
    AST_VALID_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rec_valid); // R3
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rec_valid |=> !rec_valid); // R3
    AST_NO_START_FULL: assert property (@(posedge clk) disable iff (rst)
        (start && q_full && !busy) |=> !busy); // R4
    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$rose(busy)) |-> step == $past(step) + 1'b1); // R5
    AST_FULL_WITH_BUSY: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && $past(q_last)) |-> full_stat); // R6

endmodule

// File: rtl/mrp_gather.sv
module mrp_gather
    import mrp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SUBW-1:0]  step,
    input  logic [CODEW-1:0] code,
    input  mv_t              mv_in,
    input  logic             zero_in,
    input  logic [RIDW-1:0]  rid_in,
    input  logic [FLGW-1:0]  flags_in,
    output logic [SUBW-1:0]  src_sub,
    output logic [PARTW-1:0] src_part,
    output logic [RECW-1:0]  rec_data
);

    logic [PARTW-1:0] cur_part;
    mv_t              mv_q  [SUBS];
    logic [SUBS-1:0]  zf_q;
    logic [RIDW-1:0]  rid_q [PARTS];
    logic [FLGW-1:0]  flg_q;

    assign cur_part = step[SUBW-1 -: PARTW];
    assign src_sub  = step & sub_mask(code, cur_part);
    assign src_part = cur_part & part_mask(code);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SUBS; i++) mv_q[i] <= '0;
            for (int p = 0; p < PARTS; p++) rid_q[p] <= '0;
            zf_q  <= '0;
            flg_q <= '0;
        end else if (en) begin
            mv_q[step] <= mv_in;
            zf_q[step] <= zero_in;
            if (step[SUBW-PARTW-1:0] == '0) rid_q[cur_part] <= rid_in;
            if (step == SUBW'(LASTSTEP)) flg_q <= flags_in;
        end
    end

    for (genvar w = 0; w < SUBS; w++) begin : g_word
        logic [UPW-1:0] up;
        if (w % GRP == 0) begin : g_rid
            assign up = UPW'(rid_q[w / GRP]);
        end else if (w % GRP == 1) begin : g_zero
            assign up = UPW'(zf_q[(w - 1) +: GRP]);
        end else if (w == SUBS - 1) begin : g_flags
            assign up = UPW'(flg_q);
        end else begin : g_none
            assign up = '0;
        end
        assign rec_data[w*WORDW +: WORDW] = {up, mv_q[w]};
    end

    AST_SRC_IN_PART: assert property (@(posedge clk) disable iff (rst)
        en |-> src_sub[SUBW-1 -: PARTW] == (cur_part & part_mask(code))); // R8
    AST_WORD_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        rec_data[3*WORDW-1 -: UPW] == '0); // R11

endmodule

// File: rtl/motion_record_packer.sv
module motion_record_packer
    import mrp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stg_we,
    input  logic [ADDRW-1:0]     stg_addr,
    input  logic [CELLW-1:0]     stg_wdata,
    input  logic                 start,
    input  logic                 q_full,
    input  logic                 q_last,
    output logic                 busy,
    output logic                 full_stat,
    output logic                 rec_valid,
    output logic [RECW-1:0]      rec_data
);

    logic [SUBW-1:0]  step;
    logic [SUBW-1:0]  src_sub;
    logic [PARTW-1:0] src_part;
    mv_t              rd_mv;
    logic             rd_zero;
    logic [RIDW-1:0]  rd_rid;
    logic [FLGW-1:0]  flags;
    logic [CODEW-1:0] code;

    mrp_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .q_full    (q_full),
        .q_last    (q_last),
        .busy      (busy),
        .step      (step),
        .rec_valid (rec_valid),
        .full_stat (full_stat)
    );

    mrp_stage u_stage (
        .clk     (clk),
        .rst     (rst),
        .we      (stg_we),
        .addr    (stg_addr),
        .wdata   (stg_wdata),
        .rd_sub  (src_sub),
        .rd_part (src_part),
        .rd_mv   (rd_mv),
        .rd_zero (rd_zero),
        .rd_rid  (rd_rid),
        .flags   (flags),
        .code    (code)
    );

    mrp_gather u_gather (
        .clk      (clk),
        .rst      (rst),
        .en       (busy),
        .step     (step),
        .code     (code),
        .mv_in    (rd_mv),
        .zero_in  (rd_zero),
        .rid_in   (rd_rid),
        .flags_in (flags),
        .src_sub  (src_sub),
        .src_part (src_part),
        .rec_data (rec_data)
    );

    AST_REC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> $stable(rec_data)); // R3

endmodule

// File: tb/motion_record_packer_tb.sv
module motion_record_packer_tb_top;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         stg_we;
    logic [6:0]   stg_addr;
    logic [15:0]  stg_wdata;
    logic         start;
    logic         q_full;
    logic         q_last;
    logic         busy;
    logic         full_stat;
    logic         rec_valid;
    logic [511:0] rec_data;

    int checks = 0;
    int fails  = 0;

    logic [13:0] mx [16];
    logic [11:0] my [16];
    logic        mz [16];
    logic [4:0]  mr [4];
    logic [1:0]  mf;
    logic [9:0]  mc;

    always #(CLK_PERIOD/2) clk = ~clk;

    motion_record_packer dut_i (
        .clk(clk), .rst(rst), .stg_we(stg_we), .stg_addr(stg_addr),
        .stg_wdata(stg_wdata), .start(start), .q_full(q_full), .q_last(q_last),
        .busy(busy), .full_stat(full_stat), .rec_valid(rec_valid), .rec_data(rec_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] blut(input logic [1:0] v);
        case (v)
            2'd0: return 2'd0;
            2'd1: return 2'd2;
            2'd2: return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [3:0] smask(input int i);
        int p = i / 4;
        return {blut(mc[1:0]), blut(mc[2*p+2 +: 2])};
    endfunction

    function automatic logic [31:0] exp_word(input int i);
        logic [31:0] w;
        int src = i & smask(i);
        w = {6'd0, my[src], mx[src]};
        if (i % 4 == 0) w[30:26] = mr[(i/4) & blut(mc[1:0])];
        if (i % 4 == 1)
            for (int k = 0; k < 4; k++) w[26+k] = mz[((i & 12) | k) & smask(i)];
        if (i == 15) w[27:26] = mf;
        return w;
    endfunction

    // Bench model of the staging layout (R7, R12)
    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        stg_we = 1'b1; stg_addr = 7'(a); stg_wdata = d;
        @(negedge clk);
        stg_we = 1'b0;
        case (a % 8)
            0: mx[a/8] = d[13:0];
            1: my[a/8] = d[11:0];
            2: mr[a/32] = d[4:0];
            3: mz[a/8] = d[0];
            4: mf = d[1:0];
            5: mc = d[9:0];
            default: ;
        endcase
    endtask

    task automatic fill(input int s);
        for (int i = 0; i < 16; i++) begin
            wr(i*8+0, 16'(i*16'h1357 + s*16'h02F1 + 16'hC000));
            wr(i*8+1, 16'(i*16'h0B3D + s*16'h0779 + 16'hF000));
            wr(i*8+3, 16'((i*7 + s*3) % 5 < 2 ? 16'hFFFF : 16'hFFFE));
        end
        for (int p = 0; p < 4; p++)
            wr(p*32 + ((p + s) % 4)*8 + 2, 16'(p*9 + s*5 + 3 + 16'hFFE0));
        wr((s % 4)*32 + 4, 16'(s + 16'hABC0));
    endtask

    task automatic check_record(input string ov);
        logic [31:0] a, e;
        bit bad_lo = 0, bad_r = 0, bad_z = 0, bad_u = 0;
        logic [31:0] la = 0, le = 0, ra = 0, re = 0, za = 0, ze = 0, ua = 0, ue = 0;
        for (int i = 0; i < 16; i++) begin
            a = rec_data[32*i +: 32];
            e = exp_word(i);
            if (a[25:0] !== e[25:0] && !bad_lo) begin bad_lo = 1; la = a; le = e; end
            if (i % 4 == 0 && a[31:26] !== e[31:26] && !bad_r) begin bad_r = 1; ra = a; re = e; end
            if (i % 4 == 1 && a[31:26] !== e[31:26] && !bad_z) begin bad_z = 1; za = a; ze = e; end
            if (i % 4 > 1 && a[31:26] !== e[31:26] && !bad_u) begin bad_u = 1; ua = a; ue = e; end
        end
        chk(ov != "" ? ov : (mc == 10'h3FF ? "R7" : "R8"), la, le);
        chk(ov != "" ? ov : "R9", ra, re);
        chk(ov != "" ? ov : "R10", za, ze);
        chk(ov != "" ? ov : "R11", ua, ue);
    endtask

    task automatic run_gather(input bit poke, input bit last, input string ov);
        bit ok_busy = 1, ok_full = 1;
        @(negedge clk);
        start = 1'b1; q_last = last;
        chk("R6", 32'(full_stat), 32'(q_full));
        @(negedge clk);
        start = 1'b0; q_last = 1'b0;
        for (int c = 0; c < 16; c++) begin
            if (!busy || rec_valid) ok_busy = 0;
            if (full_stat !== last) ok_full = 0;
            start = (poke && c == 5);
            @(negedge clk);
        end
        start = 1'b0;
        chk(poke ? "R5" : "R2", 32'(ok_busy && !busy), 32'd1);
        chk("R3", 32'(rec_valid), 32'd1);
        if (last) chk("R6", 32'(ok_full && full_stat), 32'd1);
        check_record(ov);
        @(negedge clk);
        chk(poke ? "R5" : "R3", {30'd0, busy, rec_valid}, 32'd0);
        if (last) chk("R6", 32'(full_stat), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; stg_we = 0; stg_addr = 0; stg_wdata = 0;
        start = 0; q_full = 0; q_last = 0;
        for (int i = 0; i < 16; i++) begin mx[i] = 0; my[i] = 0; mz[i] = 0; end
        for (int p = 0; p < 4; p++) mr[p] = 0;
        mf = 0; mc = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", {29'd0, busy, rec_valid, full_stat}, 32'd0);

        // R4: start refused while queue has no space
        q_full = 1'b1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        begin
            bit quiet = 1;
            for (int c = 0; c < 18; c++) begin
                if (busy || rec_valid) quiet = 0;
                @(negedge clk);
            end
            chk("R4", 32'(quiet), 32'd1);
            chk("R6", 32'(full_stat), 32'd1);
        end
        q_full = 1'b0;

        // Sweep every partition code across several staging fills (R7..R11)
        for (int code = 0; code < 1024; code++) begin
            if (code % 128 == 0) fill(code / 128);
            wr((code % 4)*32 + 5, 16'(code | 16'hFC00));
            run_gather(code % 97 == 5, code % 61 == 7, "");
        end

        // R12: aliases, reserved kinds, oversized data
        wr(7'h3D, 16'h0155);
        wr(7'h6C, 16'h1234);
        wr(7'h0E, 16'hFFFF);
        wr(7'h7F, 16'hFFFF);
        wr(7'h46, 16'hFFFF);
        wr(7'h65, 16'hFFFF);
        wr(7'h5A, 16'hFFF6);
        run_gather(1'b0, 1'b0, "R12");
        wr(7'h1C, 16'hFFFD);
        wr(7'h7A, 16'h0011);
        wr(7'h05, 16'h0324);
        run_gather(1'b0, 1'b0, "R12");

        // R5 and R6 together
        run_gather(1'b1, 1'b1, "");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule